// File: doc/BRIEF.md
# CAS Signaling Freeze Controller

This block produces the freeze flag that an E1 receiver's signaling path uses to keep the last good channel-associated signaling state. Several conditions raise the flag: loss of signal, loss of CAS multiframe alignment, and a receive slip in either direction. Loss of signal and loss of alignment are level inputs. Slips arrive as one-cycle pulses.

Once every alarm has gone away, the flag does not drop at once. It stays up until the receive timing has delivered enough multiframe-start strobes to prove that at least `HOLD_MF` complete alarm-free multiframes have passed. A fresh alarm at any point during this wait re-arms it. A software force bit can hold the flag high on its own, and it has no effect on the hold state.

The flag is the OR of a registered hold state and the force input. An alarm therefore shows on the output one cycle after it is sampled, while the force bit shows in the same cycle.

Top module: `cas_freeze_ctrl`

## Requirements
- R1: After reset, `freeze_o` is 0 and the hold state is empty, as long as `force_i` is 0.
- R2: If `los_i` is 1 in a cycle, `freeze_o` is 1 from the next cycle on.
- R3: If `lomf_i` is 1 in a cycle, `freeze_o` is 1 from the next cycle on.
- R4: A one-cycle pulse on `slip_pos_i` or on `slip_neg_i` sets `freeze_o` to 1 from the next cycle. `freeze_o` then stays 1 after the pulse has ended.
- R5: After all alarms are clear, `freeze_o` stays 1 until a `mf_start_i` strobe arrives in an alarm-free cycle and it is strobe number `HOLD_MF`+1 of such strobes. `freeze_o` drops in the cycle after that strobe. A strobe that arrives in a cycle where an alarm is active is not counted.
- R6: Any alarm during the hold period resets the strobe count, so a full `HOLD_MF`+1 alarm-free strobes are needed again.
- R7: While `force_i` is 1, `freeze_o` is 1 in that same cycle. Setting or clearing `force_i` does not change the hold state or the strobe count.
- R8: When the hold state is empty and no alarm is present, `mf_start_i` strobes leave `freeze_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| los_i | input | 1 | Loss of signal alarm (level) |
| lomf_i | input | 1 | Loss of CAS multiframe alignment (level) |
| slip_pos_i | input | 1 | Positive receive slip (one-cycle pulse) |
| slip_neg_i | input | 1 | Negative receive slip (one-cycle pulse) |
| mf_start_i | input | 1 | Multiframe-start strobe from the receive timing |
| force_i | input | 1 | Software force of the freeze flag |
| freeze_o | output | 1 | Freeze flag, active high |

## Verification
The bench builds the block with `HOLD_MF` set to 2. With that value the hold runs through several counted strobes, so the bench can observe the count and a re-arm in the middle of the count, which a single-multiframe hold would not show. It also places strobes in the same cycle as alarms, to confirm that such strobes are not counted. It applies the force bit both with the hold state empty and with a hold in progress.

// File: rtl/cfz_pkg.sv
package cfz_pkg;
  typedef struct packed {
    logic los;
    logic lomf;
    logic slip_pos;
    logic slip_neg;
  } cfz_alarm_t;
endpackage

// File: rtl/cfz_alarm_merge.sv
module cfz_alarm_merge
  import cfz_pkg::*;
(
  input  cfz_alarm_t alarms_i,
  output logic       alarm_o
);
  // any level alarm or slip pulse counts as an alarm cycle
  assign alarm_o = |alarms_i;
endmodule

// File: rtl/cfz_hold_ctr.sv
module cfz_hold_ctr #(
  parameter int unsigned HOLD_MF = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic mf_start_i,
  output logic hold_o
);
  localparam int unsigned CW = (HOLD_MF < 1) ? 1 : $clog2(HOLD_MF + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MF);

  logic          hold_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (alarm_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && mf_start_i) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

  p_alarm_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |=> hold_q);
  p_release_on_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> ($past(mf_start_i) && !$past(alarm_i)));
  p_idle_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !alarm_i) |=> !hold_q);
  p_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |=> (cnt_q == '0));
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/cas_freeze_ctrl.sv
module cas_freeze_ctrl
  import cfz_pkg::*;
#(
  parameter int unsigned HOLD_MF = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic los_i,
  input  logic lomf_i,
  input  logic slip_pos_i,
  input  logic slip_neg_i,
  input  logic mf_start_i,
  input  logic force_i,
  output logic freeze_o
);
  cfz_alarm_t alarms;
  logic       alarm;
  logic       hold;

  assign alarms = '{los: los_i, lomf: lomf_i, slip_pos: slip_pos_i, slip_neg: slip_neg_i};

  cfz_alarm_merge i_merge (
    .alarms_i (alarms),
    .alarm_o  (alarm)
  );

  cfz_hold_ctr #(.HOLD_MF(HOLD_MF)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alarm_i    (alarm),
    .mf_start_i (mf_start_i),
    .hold_o     (hold)
  );

  assign freeze_o = hold | force_i;

  p_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> freeze_o);
  p_los_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |=> freeze_o);
  p_lomf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lomf_i |=> freeze_o);
  p_slip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_pos_i || slip_neg_i) |=> freeze_o);
endmodule

// File: tb/test_cas_freeze_ctrl.sv
module test_cas_freeze_ctrl;
  localparam int unsigned B_HOLD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic los = 0, lomf = 0, sp = 0, sn = 0, mf = 0, frc = 0;
  logic freeze;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];

  bit mdl_hold = 0;
  int mdl_cnt  = 0;

  always #2 clk = ~clk;

  cas_freeze_ctrl #(.HOLD_MF(B_HOLD)) i_cas_freeze_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .los_i      (los),
    .lomf_i     (lomf),
    .slip_pos_i (sp),
    .slip_neg_i (sn),
    .mf_start_i (mf),
    .force_i    (frc),
    .freeze_o   (freeze)
  );

  // driver: apply inputs for one cycle, push expected output after the edge
  task automatic step(input bit l, input bit m, input bit p, input bit n,
                      input bit s, input bit f, input string tag);
    @(negedge clk);
    los = l; lomf = m; sp = p; sn = n; mf = s; frc = f;
    if (l || m || p || n) begin
      mdl_hold = 1; mdl_cnt = 0;
    end else if (mdl_hold && s) begin
      if (mdl_cnt == B_HOLD) begin
        mdl_hold = 0; mdl_cnt = 0;
      end else mdl_cnt++;
    end
    exp_q.push_back(mdl_hold | f);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: sample after the edge, while inputs still hold
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (freeze !== e) begin
          errors++;
          $display("FAIL %s freeze_o actual=%b expected=%b", t, freeze, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (freeze !== 1'b0) begin
      errors++;
      $display("FAIL R1 freeze_o in reset actual=%b expected=0", freeze);
    end
    rst_n = 1'b1;
    idle(2, "R1");

    // R8: strobes with empty hold
    step(0, 0, 0, 0, 1, 0, "R8");
    idle(2, "R8");
    step(0, 0, 0, 0, 1, 0, "R8");

    // R2: LOS level, strobes during alarm do not count
    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 1, 0, "R2");
    step(1, 0, 0, 0, 1, 0, "R5");
    // R5: three alarm-free strobes needed with HOLD_MF=2
    for (int i = 0; i < 3; i++) begin
      idle(3, "R5");
      step(0, 0, 0, 0, 1, 0, "R5");
    end
    idle(2, "R5");

    // R3: loss of multiframe alignment
    step(0, 1, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 0, 1, 0, "R5");
      idle(1, "R5");
    end

    // R4: positive slip pulse
    step(0, 0, 1, 0, 0, 0, "R4");
    idle(4, "R4");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R5");
    idle(1, "R4");
    // R4: negative slip pulse
    step(0, 0, 0, 1, 0, 0, "R4");
    idle(3, "R4");

    // R6: re-arm mid-count (two strobes counted, then slip)
    step(0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 1, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    idle(2, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    idle(2, "R6");

    // R7: force with empty hold, then release
    step(0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    // R7: force during hold does not disturb the count
    step(1, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 1, "R7");
    idle(3, "R7");

    @(negedge clk);
    los = 0; lomf = 0; sp = 0; sn = 0; mf = 0; frc = 0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule